// File: doc/BRIEF.md
# Dual-Port Mailbox Memory

This block is a synchronous two-port word store. Each port has its own active-low select, write strobe and output enable, plus an address and a data bus. Either port may read or write any word. Read data is registered, so it appears one clock after the access together with a drive-enable output. A port whose output enable is high, or that is writing, shows zeros with the drive enable low.

The two highest addresses are shared message slots. The word just below the top belongs to the left port. The top word belongs to the right port. When one port writes the slot owned by the other port, the owner's active-low interrupt goes low. The owner drops the interrupt again by accessing its slot with select and output enable low. Both slots still hold ordinary data that either side may read or write.

Each port also has an active-low hold input. While a port's hold is low, its writes do not reach the array, and its accesses neither raise nor drop any interrupt.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both interrupt outputs are high and both drive-enable outputs are low with zero read data.
- R2: A port with select low, write strobe low and hold high stores its write data at its address. A later read of that address from either port returns that data.
- R3: A read is select low, output enable low and write strobe high. It gives the stored word on the read data output with the drive enable high one clock later. In any other cycle the next clock leaves the drive enable low and the read data zero.
- R4: An accepted right-port write to address 2^ADDR_W-2 drives the left interrupt low one clock later.
- R5: A left access to address 2^ADDR_W-2 with select low, output enable low and hold high raises the left interrupt one clock later, whether the write strobe is high or low.
- R6: An accepted left-port write to address 2^ADDR_W-1 drives the right interrupt low one clock later. A right access to that address with select low, output enable low and hold high raises it again.
- R7: Both slot addresses store and return data like any other word. Accesses to any other address leave both interrupts unchanged.
- R8: When the hold input of the port that would set or clear an interrupt is low, that interrupt keeps its value.
- R9: A write from a port whose hold input is low leaves the array unchanged.
- R10: When a set and a clear of the same interrupt fall in one cycle, the interrupt ends low.
- R11: When both ports write the same address in one cycle, the left port's data is stored.
- R12: A read in the same cycle as a write to the same address, from either port, returns the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_busy_n | input | 1 | Left hold, active low; blocks writes and interrupt changes |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_dout_en | output | 1 | Left read data valid / drive enable |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_busy_n | input | 1 | Right hold, active low; blocks writes and interrupt changes |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_dout_en | output | 1 | Right read data valid / drive enable |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with ADDR_W set to 6 and DATA_W left at 8. The array is then 64 words, so one port can fill every word with a computed pattern and the other can read it all back in a few hundred cycles. With this size the two slot addresses, 62 and 63, sit next to ordinary words. That makes it easy to check that neighbouring addresses leave the interrupts alone. The same-cycle cases can then be aimed at a slot: set against clear, left against right write, and read against write.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  // Slot owned by a side: left owns the word below the top, right owns the top.
  function automatic int unsigned mbx_addr(input int unsigned aw, input side_e side);
    return (32'd1 << aw) - 32'd2 + ((side == SIDE_R) ? 32'd1 : 32'd0);
  endfunction

  function automatic logic is_write(input logic cs_n, input logic we_n);
    return !cs_n && !we_n;
  endfunction

  function automatic logic is_read(input logic cs_n, input logic we_n, input logic oe_n);
    return !cs_n && !oe_n && we_n;
  endfunction

  function automatic logic is_touch(input logic cs_n, input logic oe_n);
    return !cs_n && !oe_n;
  endfunction

endpackage

// File: rtl/dpm_port_ctl.sv
module dpm_port_ctl
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter side_e       SIDE   = SIDE_L
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_go,
  output logic              rd_go,
  output logic              peer_set,
  output logic              own_clr
);
  localparam side_e             PEER     = (SIDE == SIDE_L) ? SIDE_R : SIDE_L;
  localparam logic [ADDR_W-1:0] OWN_MBX  = ADDR_W'(mbx_addr(ADDR_W, SIDE));
  localparam logic [ADDR_W-1:0] PEER_MBX = ADDR_W'(mbx_addr(ADDR_W, PEER));

  always_comb begin
    wr_go    = is_write(cs_n, we_n) && busy_n;
    rd_go    = is_read(cs_n, we_n, oe_n);
    peer_set = wr_go && (addr == PEER_MBX);
    own_clr  = is_touch(cs_n, oe_n) && busy_n && (addr == OWN_MBX);
  end
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      irq_n_o <= 1'b1;
    else if (set_i)  irq_n_o <= 1'b0;
    else if (clr_i)  irq_n_o <= 1'b1;
  end
endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port a is applied last, so it wins an address collision.
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      a_rdata  <= '0;
      b_rvalid <= 1'b0;
      b_rdata  <= '0;
    end else begin
      a_rvalid <= a_rd;
      a_rdata  <= a_rd ? mem[a_addr] : '0;
      b_rvalid <= b_rd;
      b_rdata  <= b_rd ? mem[b_addr] : '0;
    end
  end
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_dout_en,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_dout_en,
  output logic              r_irq_n
);
  localparam int unsigned NPORT = 2;

  logic [NPORT-1:0]             cs_n, we_n, oe_n, busy_n;
  logic [NPORT-1:0][ADDR_W-1:0] addr;
  logic [NPORT-1:0]             wr_go, rd_go, peer_set, own_clr;
  logic [NPORT-1:0]             flag_set, flag_clr, irq_n;

  assign cs_n   = {r_cs_n, l_cs_n};
  assign we_n   = {r_we_n, l_we_n};
  assign oe_n   = {r_oe_n, l_oe_n};
  assign busy_n = {r_busy_n, l_busy_n};
  assign addr   = {r_addr, l_addr};

  // A side's flag is raised by the opposite side and dropped by its own.
  assign flag_set = {peer_set[0], peer_set[1]};
  assign flag_clr = own_clr;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpm_port_ctl #(
      .ADDR_W(ADDR_W),
      .SIDE  (side_e'(g))
    ) u_ctl (
      .cs_n    (cs_n[g]),
      .we_n    (we_n[g]),
      .oe_n    (oe_n[g]),
      .busy_n  (busy_n[g]),
      .addr    (addr[g]),
      .wr_go   (wr_go[g]),
      .rd_go   (rd_go[g]),
      .peer_set(peer_set[g]),
      .own_clr (own_clr[g])
    );

    dpm_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .irq_n_o(irq_n[g])
    );
  end

  dpm_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_wr    (wr_go[0]),
    .a_rd    (rd_go[0]),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_rdata (l_rdata),
    .a_rvalid(l_dout_en),
    .b_wr    (wr_go[1]),
    .b_rd    (rd_go[1]),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_rdata (r_rdata),
    .b_rvalid(r_dout_en)
  );

  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];
endmodule

// File: rtl/dpm_mailbox_ram_sva.sv
module dpm_mailbox_ram_sva #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_cs_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic              l_busy_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_dout_en,
  input logic              l_irq_n,
  input logic              r_cs_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic              r_busy_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_dout_en,
  input logic              r_irq_n,
  input logic [1:0]        flag_set,
  input logic [1:0]        flag_clr
);
  localparam logic [ADDR_W-1:0] SLOT_L = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] SLOT_R = ADDR_W'((1 << ADDR_W) - 1);

  logic r_hits_l, l_hits_r, l_reads_own, r_reads_own;
  assign r_hits_l    = !r_cs_n && !r_we_n && r_busy_n && (r_addr == SLOT_L);
  assign l_hits_r    = !l_cs_n && !l_we_n && l_busy_n && (l_addr == SLOT_R);
  assign l_reads_own = !l_cs_n && !l_oe_n && l_busy_n && (l_addr == SLOT_L);
  assign r_reads_own = !r_cs_n && !r_oe_n && r_busy_n && (r_addr == SLOT_R);

  assert_left_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    r_hits_l |=> !l_irq_n);

  assert_left_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_reads_own && !r_hits_l) |=> l_irq_n);

  assert_right_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    l_hits_r |=> !r_irq_n);

  assert_right_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_reads_own && !l_hits_r) |=> r_irq_n);

  assert_left_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_set[0] && !flag_clr[0]) |=> $stable(l_irq_n));

  assert_right_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_set[1] && !flag_clr[1]) |=> $stable(r_irq_n));

  assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !l_oe_n && l_we_n) |=> l_dout_en);

  assert_read_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_cs_n && !l_oe_n && l_we_n) |=> (!l_dout_en && l_rdata == '0));

  assert_right_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && !r_oe_n && r_we_n) |=> r_dout_en);
endmodule

bind dpm_mailbox_ram dpm_mailbox_ram_sva #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .l_cs_n   (l_cs_n),
  .l_we_n   (l_we_n),
  .l_oe_n   (l_oe_n),
  .l_busy_n (l_busy_n),
  .l_addr   (l_addr),
  .l_rdata  (l_rdata),
  .l_dout_en(l_dout_en),
  .l_irq_n  (l_irq_n),
  .r_cs_n   (r_cs_n),
  .r_we_n   (r_we_n),
  .r_oe_n   (r_oe_n),
  .r_busy_n (r_busy_n),
  .r_addr   (r_addr),
  .r_dout_en(r_dout_en),
  .r_irq_n  (r_irq_n),
  .flag_set (flag_set),
  .flag_clr (flag_clr)
);

// File: tb/dpm_mailbox_ram_tb.sv
module dpm_mailbox_ram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] SLOT_L = AW'(DEPTH - 2);
  localparam logic [AW-1:0] SLOT_R = AW'(DEPTH - 1);

  logic clk = 1'b0;
  logic rst_n;
  logic l_cs_n, l_we_n, l_oe_n, l_busy_n;
  logic r_cs_n, r_we_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_dout_en, r_dout_en, l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_dout_en(l_dout_en), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_dout_en(r_dout_en), .r_irq_n(r_irq_n)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = '0; l_wdata = '0;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = '0; r_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_l(input logic we_n, input logic oe_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs_n = 0; l_we_n = we_n; l_oe_n = oe_n; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(input logic we_n, input logic oe_n, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs_n = 0; r_we_n = we_n; r_oe_n = oe_n; r_addr = a; r_wdata = d;
  endtask

  task automatic wr_l(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle(); set_l(0, 1, a, d); tick(); idle();
  endtask

  task automatic wr_r(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle(); set_r(0, 1, a, d); tick(); idle();
  endtask

  task automatic rd_l_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    idle(); set_l(1, 0, a, '0); tick();
    check(req, l_dout_en, 1); check(req, l_rdata, exp); idle();
  endtask

  task automatic rd_r_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    idle(); set_r(1, 0, a, '0); tick();
    check(req, r_dout_en, 1); check(req, r_rdata, exp); idle();
  endtask

  task automatic t_reset();
    idle(); rst_n = 0; tick(); tick(); rst_n = 1;
    check("R1 l_irq_n", l_irq_n, 1);
    check("R1 r_irq_n", r_irq_n, 1);
    check("R1 l_dout_en", l_dout_en, 0);
    check("R1 r_dout_en", r_dout_en, 0);
    check("R1 l_rdata", l_rdata, 0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH - 2; a++) wr_l(AW'(a), pat(a));
    for (int a = 0; a < DEPTH - 2; a++) rd_r_chk("R2 left->right", AW'(a), pat(a));
    wr_r(AW'(5), 8'hC3);
    rd_l_chk("R2 right->left", AW'(5), 8'hC3);
    check("R7 no irq from plain words L", l_irq_n, 1);
    check("R7 no irq from plain words R", r_irq_n, 1);
  endtask

  task automatic t_read_ctl();
    idle(); set_l(1, 1, AW'(5), '0); tick();
    check("R3 oe high no drive", l_dout_en, 0);
    check("R3 oe high zero data", l_rdata, 0);
    idle(); set_l(0, 0, AW'(6), 8'h77); tick();
    check("R3 write no drive", l_dout_en, 0);
    idle(); tick();
    check("R3 idle no drive", r_dout_en, 0);
    rd_r_chk("R2 write with oe low stored", AW'(6), 8'h77);
  endtask

  task automatic t_mbx_left();
    wr_r(SLOT_L, 8'hA1);
    check("R4 left irq set", l_irq_n, 0);
    check("R4 right irq untouched", r_irq_n, 1);
    rd_r_chk("R7 slot readable by writer", SLOT_L, 8'hA1);
    check("R4 irq held after writer read", l_irq_n, 0);
    rd_l_chk("R7 slot data to owner", SLOT_L, 8'hA1);
    check("R5 left irq cleared by read", l_irq_n, 1);
    wr_r(SLOT_L, 8'hA2);
    check("R4 left irq set again", l_irq_n, 0);
    idle(); set_l(0, 0, SLOT_L, 8'hB2); tick(); idle();
    check("R5 clear with write strobe low", l_irq_n, 1);
    rd_r_chk("R7 slot written by owner", SLOT_L, 8'hB2);
  endtask

  task automatic t_mbx_right();
    wr_l(SLOT_R, 8'h3C);
    check("R6 right irq set", r_irq_n, 0);
    check("R6 left irq untouched", l_irq_n, 1);
    wr_l(SLOT_R - AW'(2), 8'h01);
    check("R7 neighbour word no change", r_irq_n, 0);
    rd_r_chk("R6 slot data to owner", SLOT_R, 8'h3C);
    check("R6 right irq cleared", r_irq_n, 1);
  endtask

  task automatic t_busy();
    idle(); set_r(0, 1, SLOT_L, 8'hEE); r_busy_n = 0; tick(); idle();
    check("R8 held writer no set", l_irq_n, 1);
    rd_l_chk("R9 held write not stored", SLOT_L, 8'hB2);
    idle(); set_l(0, 1, AW'(9), 8'h99); l_busy_n = 0; tick(); idle();
    rd_r_chk("R9 held left write not stored", AW'(9), pat(9));
    wr_r(SLOT_L, 8'h44);
    check("R4 set before held clear", l_irq_n, 0);
    idle(); set_l(1, 0, SLOT_L, '0); l_busy_n = 0; tick(); idle();
    check("R8 held owner no clear", l_irq_n, 0);
    rd_l_chk("R5 release clears", SLOT_L, 8'h44);
    check("R5 cleared after hold", l_irq_n, 1);
  endtask

  task automatic t_race();
    idle(); set_r(0, 1, SLOT_L, 8'h55); set_l(1, 0, SLOT_L, '0); tick();
    check("R12 read sees old slot word", l_rdata, 8'h44);
    idle();
    check("R10 set wins over clear", l_irq_n, 0);
    rd_l_chk("R2 new slot word", SLOT_L, 8'h55);
    idle(); set_l(0, 1, AW'(12), 8'h12); set_r(0, 1, AW'(12), 8'h34); tick(); idle();
    rd_r_chk("R11 left wins collision", AW'(12), 8'h12);
    idle(); set_l(0, 1, AW'(13), 8'hF0); set_r(1, 0, AW'(13), '0); tick();
    check("R12 cross-port read old", r_rdata, pat(13));
    idle();
    rd_r_chk("R12 new word after", AW'(13), 8'hF0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_read_ctl();
    t_mbx_left();
    t_mbx_right();
    t_busy();
    t_race();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule